// File: doc/BRIEF.md
# Serial Flash Read Line Buffer

This block sits between a memory-mapped read window and a serial flash sequence engine. It keeps one line of flash data. A read whose address falls inside the held line is answered in the same cycle. A read outside the line starts a refill. The buffer asks the sequencer for a whole line and passes along a programmable command-sequence index. It takes the returned words in order and then serves the read that is waiting.

The line length is programmed in 8-byte units. The requested count is rounded down to a power of two, raised to one unit if it is zero, and capped at the storage size. The maximum is 1 KiB at the default parameters; a build with `MAX_UNITS` set to 16 gives a 128-byte buffer. Software pulses the flush input after a flash write, an erase or a chip-select change. The flush drops the held line and abandons any refill in progress, so stale flash contents are never returned.

Top module: `flash_line_prefetch`

## Requirements
- R1: After reset no line is held: `rd_ready` and `fill_req` are low, and the first read starts a refill.
- R2: A read that misses while the block is idle raises `fill_req` for exactly one cycle, in the cycle after the read is presented. In that cycle `fill_addr` is the read address rounded down to the line size (so its low 3 bits are zero), and `fill_seq` equals `cfg_seq`.
- R3: During a refill, `rd_ready` stays low. A read that waits on an N-word refill gets `rd_ready` exactly N+2 cycles after it was first presented, when fill words arrive on back-to-back cycles starting the cycle after `fill_req`.
- R4: `rd_ready` is high only while `rd_req` is high. `rd_data` is then the fill word whose position in the line equals the read's word offset: fill word k covers line byte offset 4k.
- R5: A read inside the held line is answered in the cycle it is presented, and it issues no refill.
- R6: A line holds 2·U 32-bit words. U is `cfg_units` rounded down to a power of two, with 0 treated as 1, and capped at `MAX_UNITS`. `fill_words` shows that count during `fill_req`.
- R7: `cfg_units` and `cfg_seq` are sampled when a refill starts. Changing them later does not change whether a read hits the held line.
- R8: A flush invalidates the held line. The next read of that line misses and refills.
- R9: A flush during a refill abandons it. `fill_valid` beats that arrive afterwards are ignored, and no `fill_req` follows until a new read is presented.
- R10: A flush takes priority over a read in the same cycle: `rd_ready` stays low in that cycle.
- R11: A read outside the held line replaces it. The new line is fetched, and a later read of the old line misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Drop the held line and abort any refill |
| cfg_units | input | 8 | Line size in 8-byte units |
| cfg_seq | input | SEQ_W | Command-sequence index used for refills |
| rd_req | input | 1 | Read request, held until `rd_ready` |
| rd_addr | input | ADDR_W | Byte address of the read; low 2 bits ignored |
| rd_ready | output | 1 | Read answered this cycle |
| rd_data | output | DATA_W | Read data, valid with `rd_ready` |
| fill_req | output | 1 | One-cycle refill request |
| fill_addr | output | ADDR_W | Line base address for the refill |
| fill_words | output | CNT_W | Number of words in the refill |
| fill_seq | output | SEQ_W | Sequence index for the refill |
| fill_valid | input | 1 | A refill word is present |
| fill_data | input | DATA_W | Refill word, in ascending address order |

## Verification
The hardest case to reach from the ports is a flush that lands in the middle of a refill, followed by stray words from the sequencer. To get there, the bench turns off its automatic sequencer model and drives the fill port by hand. It delivers part of a line, pulses flush, and then keeps sending words that carry wrong data. It confirms that no refill request appears during the stray words. A fresh read must then pay the full refill latency and return correct data. A second hard case is the line-size latch: the bench reprograms the unit count between two reads of one line, and the second read must still hit.

// File: rtl/flp_pkg.sv
package flp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_FILL = 2'd2
    } flp_state_e;

    // log2 of line bytes for a unit count: highest set bit, zero counts as one unit
    function automatic logic [4:0] flp_line_lg(input logic [7:0] units);
        logic [4:0] p;
        p = 5'd0;
        for (int i = 0; i < 8; i++) begin
            if (units[i]) p = 5'(i);
        end
        return p + 5'd3;
    endfunction

endpackage

// File: rtl/flp_store.sv
module flp_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/flp_ctrl.sv
module flp_ctrl
    import flp_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int SEQ_W     = 4,
    parameter int MAX_UNITS = 128,
    parameter int WB_LG     = 2,
    parameter int IDX_W     = 8,
    parameter int CNT_W     = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [7:0]        cfg_units,
    input  logic [SEQ_W-1:0]  cfg_seq,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [CNT_W-1:0]  fill_words,
    output logic [SEQ_W-1:0]  fill_seq,
    input  logic              fill_valid,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx
);

    localparam logic [4:0] LG_MAX = 5'(3 + $clog2(MAX_UNITS));

    flp_state_e        state_q;
    logic              valid_q;
    logic [ADDR_W-1:0] base_q;
    logic [4:0]        lg_q;
    logic [IDX_W-1:0]  cnt_q;
    logic [SEQ_W-1:0]  seq_q;

    logic              hit;
    logic              idle;
    logic              miss_start;
    logic              last_word;
    logic [4:0]        new_lg;
    logic [ADDR_W-1:0] cur_mask;
    logic [ADDR_W-1:0] new_mask;

    always_comb begin
        new_lg = flp_line_lg(cfg_units);
        if (new_lg > LG_MAX) new_lg = LG_MAX;
    end

    assign cur_mask   = (ADDR_W'(1) << lg_q) - ADDR_W'(1);
    assign new_mask   = (ADDR_W'(1) << new_lg) - ADDR_W'(1);
    assign idle       = (state_q == ST_IDLE);
    assign hit        = valid_q && ((rd_addr >> lg_q) == (base_q >> lg_q));
    assign rd_ready   = rd_req && !flush && idle && hit;
    assign miss_start = rd_req && !flush && idle && !hit;
    assign rd_idx     = IDX_W'((rd_addr & cur_mask) >> WB_LG);

    assign fill_req   = (state_q == ST_REQ);
    assign fill_addr  = base_q;
    assign fill_words = CNT_W'(1) << (lg_q - 5'(WB_LG));
    assign fill_seq   = seq_q;

    assign wr_en      = (state_q == ST_FILL) && fill_valid && !flush;
    assign wr_idx     = cnt_q;
    assign last_word  = wr_en && (cnt_q == IDX_W'(fill_words - CNT_W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            valid_q <= 1'b0;
            base_q  <= '0;
            lg_q    <= 5'd3;
            cnt_q   <= '0;
            seq_q   <= '0;
        end else if (flush) begin
            state_q <= ST_IDLE;
            valid_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (miss_start) begin
                        base_q  <= rd_addr & ~new_mask;
                        lg_q    <= new_lg;
                        seq_q   <= cfg_seq;
                        valid_q <= 1'b0;
                        cnt_q   <= '0;
                        state_q <= ST_REQ;
                    end
                end
                ST_REQ: state_q <= ST_FILL;
                ST_FILL: begin
                    if (wr_en) cnt_q <= cnt_q + IDX_W'(1);
                    if (last_word) begin
                        valid_q <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/flash_line_prefetch.sv
module flash_line_prefetch
    import flp_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 32,
    parameter int SEQ_W     = 4,
    parameter int MAX_UNITS = 128,
    localparam int WB       = DATA_W / 8,
    localparam int WB_LG    = $clog2(WB),
    localparam int DEPTH    = MAX_UNITS * 8 / WB,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [7:0]        cfg_units,
    input  logic [SEQ_W-1:0]  cfg_seq,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [CNT_W-1:0]  fill_words,
    output logic [SEQ_W-1:0]  fill_seq,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data
);

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;

    flp_ctrl #(
        .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .MAX_UNITS(MAX_UNITS),
        .WB_LG(WB_LG), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .flush(flush),
        .cfg_units(cfg_units), .cfg_seq(cfg_seq),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_idx(rd_idx),
        .fill_req(fill_req), .fill_addr(fill_addr), .fill_words(fill_words),
        .fill_seq(fill_seq), .fill_valid(fill_valid),
        .wr_en(wr_en), .wr_idx(wr_idx)
    );

    flp_store #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)
    ) u_store (
        .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(fill_data),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

endmodule

// File: rtl/flash_line_prefetch_chk.sv
module flash_line_prefetch_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              flush,
    input logic              rd_req,
    input logic              rd_ready,
    input logic              fill_req,
    input logic [ADDR_W-1:0] fill_addr
);

    // R2
    fill_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fill_req |=> !fill_req);

    // R2
    fill_align_chk: assert property (@(posedge clk) disable iff (rst)
        fill_req |-> (fill_addr[2:0] == 3'b000));

    // R4
    ready_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        rd_ready |-> rd_req);

    // R3
    no_ready_in_fill_chk: assert property (@(posedge clk) disable iff (rst)
        fill_req |-> !rd_ready);

    // R8
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> !rd_ready);

    // R9
    flush_abort_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> !fill_req);

endmodule

bind flash_line_prefetch flash_line_prefetch_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .flush(flush), .rd_req(rd_req),
    .rd_ready(rd_ready), .fill_req(fill_req), .fill_addr(fill_addr)
);

// File: tb/flash_line_prefetch_tb.sv
module flash_line_prefetch_tb;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 32;
    localparam int SEQ_W  = 4;
    localparam int CNT_W  = 9;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              flush = 1'b0;
    logic [7:0]        cfg_units = 8'd4;
    logic [SEQ_W-1:0]  cfg_seq = '0;
    logic              rd_req = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              rd_ready;
    logic [DATA_W-1:0] rd_data;
    logic              fill_req;
    logic [ADDR_W-1:0] fill_addr;
    logic [CNT_W-1:0]  fill_words;
    logic [SEQ_W-1:0]  fill_seq;
    logic              fill_valid = 1'b0;
    logic [DATA_W-1:0] fill_data = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int fill_cnt = 0;
    bit seq_en = 1'b1;
    logic [ADDR_W-1:0] f_addr;
    logic [CNT_W-1:0]  f_words;
    logic [SEQ_W-1:0]  f_seq;

    always #5 clk = ~clk;

    flash_line_prefetch u_dut (
        .clk(clk), .rst(rst), .flush(flush), .cfg_units(cfg_units), .cfg_seq(cfg_seq),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .fill_req(fill_req), .fill_addr(fill_addr), .fill_words(fill_words),
        .fill_seq(fill_seq), .fill_valid(fill_valid), .fill_data(fill_data)
    );

    function automatic logic [DATA_W-1:0] wdat(input logic [ADDR_W-1:0] a);
        return {8'h5A, a[ADDR_W-1:2], 2'b00};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // flash sequencer model: answers each refill with consecutive words
    always begin
        @(negedge clk);
        if (seq_en && fill_req) begin
            f_addr = fill_addr;
            f_words = fill_words;
            f_seq = fill_seq;
            fill_cnt++;
            for (int i = 0; i < int'(f_words); i++) begin
                @(negedge clk);
                fill_valid = 1'b1;
                fill_data = wdat(ADDR_W'(f_addr + ADDR_W'(4 * i)));
            end
            @(negedge clk);
            fill_valid = 1'b0;
        end
    end

    task automatic do_read(input logic [ADDR_W-1:0] a, output int waited, output logic [DATA_W-1:0] d);
        @(negedge clk);
        rd_req = 1'b1;
        rd_addr = a;
        waited = 0;
        d = '0;
        forever begin
            #1;
            if (rd_ready) begin
                d = rd_data;
                break;
            end
            if (waited > 2000) break;
            @(negedge clk);
            waited++;
        end
        rd_req = 1'b0;
    endtask

    // addr, units, seq, expect refill, base, words
    localparam logic [70:0] VEC [13] = '{
        {24'h000104, 8'd4,   4'd3,  1'b1, 24'h000100, 10'd8},
        {24'h00011C, 8'd4,   4'd3,  1'b0, 24'h000100, 10'd8},
        {24'h000120, 8'd4,   4'd3,  1'b1, 24'h000120, 10'd8},
        {24'h000100, 8'd4,   4'd3,  1'b1, 24'h000100, 10'd8},
        {24'h000200, 8'd0,   4'd5,  1'b1, 24'h000200, 10'd2},
        {24'h000204, 8'd0,   4'd5,  1'b0, 24'h000200, 10'd2},
        {24'h000208, 8'd6,   4'd7,  1'b1, 24'h000200, 10'd8},
        {24'h00021C, 8'd6,   4'd7,  1'b0, 24'h000200, 10'd8},
        {24'h000400, 8'd200, 4'd15, 1'b1, 24'h000400, 10'd256},
        {24'h0007FC, 8'd200, 4'd15, 1'b0, 24'h000400, 10'd256},
        {24'h000800, 8'd3,   4'd9,  1'b1, 24'h000800, 10'd4},
        {24'h00080C, 8'd4,   4'd2,  1'b0, 24'h000800, 10'd4},
        {24'h000810, 8'd4,   4'd2,  1'b1, 24'h000800, 10'd8}
    };

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int w;
        int fc0;
        logic [DATA_W-1:0] d;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(rd_ready == 1'b0, "R1 ready after reset", 64'(rd_ready), 0);
        chk(fill_req == 1'b0, "R1 fill_req after reset", 64'(fill_req), 0);

        for (int v = 0; v < 13; v++) begin
            logic [23:0] a;
            logic [23:0] base;
            logic [9:0]  words;
            logic        exp_fill;
            a        = VEC[v][70:47];
            base     = VEC[v][33:10];
            words    = VEC[v][9:0];
            exp_fill = VEC[v][34];
            cfg_units = VEC[v][46:39];
            cfg_seq   = VEC[v][38:35];
            fc0 = fill_cnt;
            do_read(a, w, d);
            // R4 data ordering
            chk(d == wdat(a), "R4 read data", 64'(d), 64'(wdat(a)));
            // R5 / R11 hit or miss decision (R7 for the reprogrammed row)
            chk((fill_cnt != fc0) == exp_fill, "R5 R7 R11 refill issued", 64'(fill_cnt - fc0), 64'(exp_fill));
            if (exp_fill) begin
                chk(f_addr == base, "R2 fill address", 64'(f_addr), 64'(base));
                chk(f_seq == VEC[v][38:35], "R2 fill sequence", 64'(f_seq), 64'(VEC[v][38:35]));
                chk(f_words == CNT_W'(words), "R6 fill words", 64'(f_words), 64'(words));
                chk(w == int'(words) + 2, "R3 refill latency", 64'(w), 64'(int'(words) + 2));
            end else begin
                chk(w == 0, "R5 hit latency", 64'(w), 0);
            end
        end

        // R9: flush in the middle of a refill, then stray words
        cfg_units = 8'd4;
        cfg_seq = 4'd1;
        seq_en = 1'b0;
        @(negedge clk);
        rd_req = 1'b1;
        rd_addr = 24'h003000;
        @(negedge clk);
        rd_req = 1'b0;
        chk(fill_req == 1'b1, "R2 fill_req before abort", 64'(fill_req), 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            fill_valid = 1'b1;
            fill_data = wdat(24'(24'h003000 + 4 * i));
        end
        @(negedge clk);
        flush = 1'b1;
        fill_data = 32'hDEAD0003;
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < 5; i++) begin
            fill_data = 32'hDEAD0010 + 32'(i);
            #1;
            chk(fill_req == 1'b0, "R9 no request on stray words", 64'(fill_req), 0);
            @(negedge clk);
        end
        fill_valid = 1'b0;
        seq_en = 1'b1;
        fc0 = fill_cnt;
        do_read(24'h003004, w, d);
        chk(fill_cnt == fc0 + 1, "R9 new refill after abort", 64'(fill_cnt - fc0), 1);
        chk(w == 10, "R9 full refill latency after abort", 64'(w), 10);
        chk(d == wdat(24'h003004), "R9 data after abort", 64'(d), 64'(wdat(24'h003004)));

        // R10: flush and read in the same cycle on a held line
        @(negedge clk);
        rd_req = 1'b1;
        rd_addr = 24'h003008;
        flush = 1'b1;
        #1;
        chk(rd_ready == 1'b0, "R10 flush beats read", 64'(rd_ready), 0);
        @(negedge clk);
        flush = 1'b0;
        rd_req = 1'b0;

        // R8: line dropped by the flush
        fc0 = fill_cnt;
        do_read(24'h003008, w, d);
        chk(fill_cnt == fc0 + 1, "R8 miss after flush", 64'(fill_cnt - fc0), 1);
        chk(d == wdat(24'h003008), "R8 data after flush", 64'(d), 64'(wdat(24'h003008)));

        // R11: old line gone after replacement
        fc0 = fill_cnt;
        do_read(24'h000104, w, d);
        chk(fill_cnt == fc0 + 1, "R11 replaced line misses", 64'(fill_cnt - fc0), 1);

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule